// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is an execution unit that sits beside a small 32-bit integer core and takes over instructions the core does not decode itself. It covers three groups of operations. The first is scaled-index address arithmetic. The second is basic bit manipulation: logic with an inverted operand, signed and unsigned min/max, rotates, bit counts, sign and zero extension, byte OR-combine and byte reversal. The third is single-bit set, clear, invert and extract, each indexed either by a register or by an immediate.

The core presents the instruction word and both source operands together with a valid strobe. In the same cycle the unit raises `rsp_wait` when it recognises the instruction. One clock later it raises `rsp_ready` and `rsp_wr` together with the result for the destination register. The unit leaves an unknown instruction unclaimed, with no wait, ready or write, so that the core can take an illegal-instruction trap.

Top module: `bitmanip_unit`

## Requirements
- R1: OP opcode 0110011 with funct7 0010000 and funct3 010, 100 or 110 returns (src1 << 1) + src2, (src1 << 2) + src2 or (src1 << 3) + src2 respectively.
- R2: OP with funct7 0100000 returns src1 & ~src2 for funct3 111, src1 | ~src2 for funct3 110, and ~(src1 ^ src2) for funct3 100.
- R3: OP with funct7 0000101 returns the signed minimum for funct3 100, the unsigned minimum for 101, the signed maximum for 110 and the unsigned maximum for 111.
- R4: OP with funct7 0110000 rotates src1 left for funct3 001 and right for funct3 101 by src2[4:0]. OP-IMM opcode 0010011 with funct7 0110000 and funct3 101 rotates src1 right by instruction bits [24:20] and ignores src2. Higher bits of src2 are ignored.
- R5: OP-IMM with funct7 0110000 and funct3 001 returns the count of leading zeros when bits [24:20] are 0, trailing zeros when they are 1, and set bits when they are 2. A zero operand gives 32 for both zero counts.
- R6: OP-IMM with funct7 0110000 and funct3 001 sign-extends byte 0 when bits [24:20] are 4 and halfword 0 when they are 5. OP with funct7 0000100, funct3 100 and bits [24:20] equal to 0 zero-extends halfword 0.
- R7: OP-IMM funct3 101 with funct7 0010100 and bits [24:20] equal to 7 sets each byte to 0xFF when any of its bits is set and to 0x00 otherwise. The same funct3 with funct7 0110100 and bits [24:20] equal to 24 reverses the byte order.
- R8: funct3 001 with funct7 0100100, 0010100 or 0110100 clears, sets or inverts one bit of src1. funct3 101 with funct7 0100100 returns that bit in bit 0 with all other bits zero. The OP form takes the index from src2[4:0]; the OP-IMM form takes it from bits [24:20].
- R9: for a recognised instruction, `rsp_wait` is high in the cycle `req_valid` is high, and `rsp_ready` and `rsp_wr` are high with the result on the next clock.
- R10: an unrecognised instruction (for example OP funct7 0000001, OP funct7 0000101 funct3 001, or OP-IMM funct7 0110000 funct3 001 bits [24:20] = 3) leaves `rsp_wait`, `rsp_ready` and `rsp_wr` low.
- R11: while `rst` is high and on the cycle after it, `rsp_ready`, `rsp_wr` and `rsp_result` are zero.
- R12: if `req_valid` stays high after `rsp_ready`, `rsp_ready` is low on the following cycle, so one request never yields two ready pulses in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction offered by the core |
| req_insn | input | 32 | Instruction word |
| req_src1 | input | 32 | First source operand value |
| req_src2 | input | 32 | Second source operand value |
| rsp_wr | output | 1 | Write the result to the destination register |
| rsp_result | output | 32 | Result value |
| rsp_wait | output | 1 | Instruction recognised, result pending |
| rsp_ready | output | 1 | Result valid this cycle |

## Verification
Each operation is run with operands chosen to separate it from its near neighbours. Min and max use -1 against 1, so signed and unsigned orderings disagree. Rotate and bit-index inputs carry set bits above bit 4, so a design that uses more than the low five bits gives a different answer. Immediate forms get an all-ones src2, so a design that reads the register instead of the immediate fails. The zero counts are tried on zero, on the top bit and on a middle bit, and the extensions are tried with the sign bit both set and clear. Handshake tests cover a held valid, unknown encodings next to real ones, and reset.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [4:0] {
    K_SH1, K_SH2, K_SH3, K_ANDN, K_ORN, K_XNOR,
    K_MAX, K_MAXU, K_MIN, K_MINU, K_ROL, K_ROR,
    K_CLZ, K_CTZ, K_CPOP, K_SEXTB, K_SEXTH, K_ZEXTH,
    K_ORCB, K_REV8, K_BCLR, K_BSET, K_BINV, K_BEXT
  } bmu_kind_e;

  localparam logic [6:0] MAJ_REG = 7'b0110011;
  localparam logic [6:0] MAJ_IMM = 7'b0010011;
endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit,
  output bmu_kind_e   kind,
  output logic        imm_idx
);
  logic [6:0] maj, f7;
  logic [2:0] f3;
  logic [4:0] sel;
  logic       unused_fields;

  assign maj = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];
  assign sel = insn[24:20];
  assign unused_fields = ^insn[19:15] ^ ^insn[11:7];

  always_comb begin
    hit = 1'b0;
    kind = K_SH1;
    imm_idx = 1'b0;
    if (maj == MAJ_REG) begin
      hit = 1'b1;
      unique casez ({f7, f3})
        {7'b0010000, 3'b010}: kind = K_SH1;
        {7'b0010000, 3'b100}: kind = K_SH2;
        {7'b0010000, 3'b110}: kind = K_SH3;
        {7'b0100000, 3'b111}: kind = K_ANDN;
        {7'b0100000, 3'b110}: kind = K_ORN;
        {7'b0100000, 3'b100}: kind = K_XNOR;
        {7'b0000101, 3'b100}: kind = K_MIN;
        {7'b0000101, 3'b101}: kind = K_MINU;
        {7'b0000101, 3'b110}: kind = K_MAX;
        {7'b0000101, 3'b111}: kind = K_MAXU;
        {7'b0110000, 3'b001}: kind = K_ROL;
        {7'b0110000, 3'b101}: kind = K_ROR;
        {7'b0100100, 3'b001}: kind = K_BCLR;
        {7'b0010100, 3'b001}: kind = K_BSET;
        {7'b0110100, 3'b001}: kind = K_BINV;
        {7'b0100100, 3'b101}: kind = K_BEXT;
        {7'b0000100, 3'b100}: begin kind = K_ZEXTH; hit = (sel == 5'd0); end
        default: hit = 1'b0;
      endcase
    end else if (maj == MAJ_IMM) begin
      imm_idx = 1'b1;
      hit = 1'b1;
      unique casez ({f7, f3})
        {7'b0110000, 3'b001}: begin
          unique case (sel)
            5'd0: kind = K_CLZ;
            5'd1: kind = K_CTZ;
            5'd2: kind = K_CPOP;
            5'd4: kind = K_SEXTB;
            5'd5: kind = K_SEXTH;
            default: hit = 1'b0;
          endcase
        end
        {7'b0100100, 3'b001}: kind = K_BCLR;
        {7'b0010100, 3'b001}: kind = K_BSET;
        {7'b0110100, 3'b001}: kind = K_BINV;
        {7'b0100100, 3'b101}: kind = K_BEXT;
        {7'b0110000, 3'b101}: kind = K_ROR;
        {7'b0010100, 3'b101}: begin kind = K_ORCB; hit = (sel == 5'd7); end
        {7'b0110100, 3'b101}: begin kind = K_REV8; hit = (sel == 5'd24); end
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] src,
  output logic [CW-1:0]   lead,
  output logic [CW-1:0]   trail,
  output logic [CW-1:0]   ones
);
  always_comb begin
    lead  = CW'(XLEN);
    trail = CW'(XLEN);
    ones  = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (src[i]) lead = CW'(XLEN - 1 - i);
      ones = ones + CW'(src[i]);
    end
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (src[i]) trail = CW'(i);
    end
  end

  always_comb begin
    a_zero_count_r5: assert ((lead == CW'(XLEN)) == (src == '0));
  end
endmodule

// File: rtl/bmu_exec.sv
module bmu_exec
  import bmu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SW = $clog2(XLEN),
  localparam int NB = XLEN / 8
) (
  input  bmu_kind_e       kind,
  input  logic            imm_idx,
  input  logic [SW-1:0]   imm_val,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int CW = SW + 1;

  logic [SW-1:0]     idx;
  logic [XLEN-1:0]   onehot, orc, rev;
  logic [2*XLEN-1:0] rl_wide, rr_wide;
  logic [CW-1:0]     lead, trail, ones;

  assign idx     = imm_idx ? imm_val : b[SW-1:0];
  assign onehot  = XLEN'(1) << idx;
  assign rl_wide = {a, a} << idx;
  assign rr_wide = {a, a} >> idx;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign orc[8*g +: 8] = {8{|a[8*g +: 8]}};
    assign rev[8*g +: 8] = a[8*(NB-1-g) +: 8];
  end

  bmu_count #(.XLEN(XLEN)) u_count (
    .src(a), .lead(lead), .trail(trail), .ones(ones)
  );

  always_comb begin
    unique case (kind)
      K_SH1:   res = (a << 1) + b;
      K_SH2:   res = (a << 2) + b;
      K_SH3:   res = (a << 3) + b;
      K_ANDN:  res = a & ~b;
      K_ORN:   res = a | ~b;
      K_XNOR:  res = ~(a ^ b);
      K_MAX:   res = ($signed(a) > $signed(b)) ? a : b;
      K_MAXU:  res = (a > b) ? a : b;
      K_MIN:   res = ($signed(a) < $signed(b)) ? a : b;
      K_MINU:  res = (a < b) ? a : b;
      K_ROL:   res = rl_wide[2*XLEN-1:XLEN];
      K_ROR:   res = rr_wide[XLEN-1:0];
      K_CLZ:   res = XLEN'(lead);
      K_CTZ:   res = XLEN'(trail);
      K_CPOP:  res = XLEN'(ones);
      K_SEXTB: res = {{(XLEN-8){a[7]}}, a[7:0]};
      K_SEXTH: res = {{(XLEN-16){a[15]}}, a[15:0]};
      K_ZEXTH: res = {{(XLEN-16){1'b0}}, a[15:0]};
      K_ORCB:  res = orc;
      K_REV8:  res = rev;
      K_BCLR:  res = a & ~onehot;
      K_BSET:  res = a | onehot;
      K_BINV:  res = a ^ onehot;
      K_BEXT:  res = XLEN'(|(a & onehot));
      default: res = '0;
    endcase
  end

  always_comb begin
    if (kind == K_BEXT) a_extract_single_r8: assert (res[XLEN-1:1] == '0);
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_src1,
  input  logic [XLEN-1:0] req_src2,
  output logic            rsp_wr,
  output logic [XLEN-1:0] rsp_result,
  output logic            rsp_wait,
  output logic            rsp_ready
);
  logic            dec_hit, dec_imm;
  bmu_kind_e       dec_kind;
  logic [XLEN-1:0] exe_res;
  logic            accept;

  bmu_decode u_decode (
    .insn(req_insn), .hit(dec_hit), .kind(dec_kind), .imm_idx(dec_imm)
  );

  bmu_exec #(.XLEN(XLEN)) u_exec (
    .kind(dec_kind), .imm_idx(dec_imm), .imm_val(req_insn[20 +: SW]),
    .a(req_src1), .b(req_src2), .res(exe_res)
  );

  assign rsp_wait = req_valid & dec_hit;
  assign accept   = rsp_wait & ~rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready  <= 1'b0;
      rsp_wr     <= 1'b0;
      rsp_result <= '0;
    end else begin
      rsp_ready  <= accept;
      rsp_wr     <= accept;
      rsp_result <= accept ? exe_res : '0;
    end
  end

  p_ready_after_claim_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> $past(req_valid && dec_hit));
  p_wait_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_wait |-> req_valid);
  p_unclaimed_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dec_hit) |=> !rsp_wr);
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);
endmodule

// File: tb/bitmanip_unit_test.sv
module bitmanip_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_insn = '0, req_src1 = '0, req_src2 = '0;
  logic        rsp_wr, rsp_wait, rsp_ready;
  logic [31:0] rsp_result;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmanip_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
    .req_src1(req_src1), .req_src2(req_src2), .rsp_wr(rsp_wr),
    .rsp_result(rsp_result), .rsp_wait(rsp_wait), .rsp_ready(rsp_ready)
  );

  function automatic logic [31:0] rty(logic [6:0] f7, logic [2:0] f3);
    return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
  endfunction
  function automatic logic [31:0] ity(logic [6:0] f7, logic [4:0] s, logic [2:0] f3);
    return {f7, s, 5'd1, f3, 5'd3, 7'b0010011};
  endfunction

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam int NV = 38;
  // {requirement number, insn, src1, src2, expected}
  localparam logic [135:0] VEC [NV] = '{
    {8'd1, rty(7'b0010000,3'b010), 32'h0000_1000, 32'h5, 32'h0000_2005},      // R1
    {8'd1, rty(7'b0010000,3'b100), 32'h0000_1000, 32'h5, 32'h0000_4005},      // R1
    {8'd1, rty(7'b0010000,3'b110), 32'h0000_1000, 32'h5, 32'h0000_8005},      // R1
    {8'd2, rty(7'b0100000,3'b111), 32'hF0F0_FFFF, 32'h0F0F_00FF, 32'hF0F0_FF00}, // R2
    {8'd2, rty(7'b0100000,3'b110), 32'h0000_0001, 32'hFFFF_FFF0, 32'h0000_000F}, // R2
    {8'd2, rty(7'b0100000,3'b100), 32'hAAAA_AAAA, 32'h5555_5555, 32'h0},      // R2
    {8'd3, rty(7'b0000101,3'b110), ONES, 32'h1, 32'h1},                        // R3
    {8'd3, rty(7'b0000101,3'b111), ONES, 32'h1, ONES},                         // R3
    {8'd3, rty(7'b0000101,3'b100), ONES, 32'h1, ONES},                         // R3
    {8'd3, rty(7'b0000101,3'b101), ONES, 32'h1, 32'h1},                        // R3
    {8'd4, rty(7'b0110000,3'b001), 32'h8000_0001, 32'h21, 32'h0000_0003},     // R4
    {8'd4, rty(7'b0110000,3'b101), 32'h8000_0001, 32'hE4, 32'h1800_0000},     // R4
    {8'd4, ity(7'b0110000,5'd8,3'b101), 32'h1234_5678, ONES, 32'h7812_3456},  // R4
    {8'd4, rty(7'b0110000,3'b001), 32'h1234_5678, 32'h20, 32'h1234_5678},     // R4
    {8'd5, ity(7'b0110000,5'd0,3'b001), 32'h0001_0000, ONES, 32'd15},         // R5
    {8'd5, ity(7'b0110000,5'd1,3'b001), 32'h0001_0000, ONES, 32'd16},         // R5
    {8'd5, ity(7'b0110000,5'd2,3'b001), 32'hF0F0_0001, ONES, 32'd9},          // R5
    {8'd5, ity(7'b0110000,5'd0,3'b001), 32'h0, ONES, 32'd32},                 // R5
    {8'd5, ity(7'b0110000,5'd1,3'b001), 32'h0, ONES, 32'd32},                 // R5
    {8'd5, ity(7'b0110000,5'd0,3'b001), 32'h8000_0000, ONES, 32'd0},          // R5
    {8'd5, ity(7'b0110000,5'd1,3'b001), 32'h8000_0000, ONES, 32'd31},         // R5
    {8'd5, ity(7'b0110000,5'd2,3'b001), ONES, 32'h0, 32'd32},                 // R5
    {8'd6, ity(7'b0110000,5'd4,3'b001), 32'h1234_5680, ONES, 32'hFFFF_FF80},  // R6
    {8'd6, ity(7'b0110000,5'd5,3'b001), 32'hFFFF_7FFF, ONES, 32'h0000_7FFF},  // R6
    {8'd6, ity(7'b0110000,5'd5,3'b001), 32'h1234_8000, ONES, 32'hFFFF_8000},  // R6
    {8'd6, {7'b0000100,5'd0,5'd1,3'b100,5'd3,7'b0110011}, 32'hFFFF_8001, ONES, 32'h0000_8001}, // R6
    {8'd7, ity(7'b0010100,5'd7,3'b101), 32'h0100_8000, ONES, 32'hFF00_FF00},  // R7
    {8'd7, ity(7'b0110100,5'd24,3'b101), 32'h1234_5678, ONES, 32'h7856_3412}, // R7
    {8'd8, rty(7'b0010100,3'b001), 32'h0, 32'h25, 32'h0000_0020},             // R8
    {8'd8, rty(7'b0100100,3'b001), ONES, 32'h1F, 32'h7FFF_FFFF},              // R8
    {8'd8, rty(7'b0110100,3'b001), 32'h0000_000F, 32'hE0, 32'h0000_000E},     // R8
    {8'd8, rty(7'b0100100,3'b101), 32'h0000_0100, 32'h8, 32'h1},              // R8
    {8'd8, ity(7'b0010100,5'd31,3'b001), 32'h0, ONES, 32'h8000_0000},         // R8
    {8'd8, ity(7'b0100100,5'd3,3'b001), 32'h0000_00FF, ONES, 32'h0000_00F7},  // R8
    {8'd8, ity(7'b0110100,5'd16,3'b001), 32'h0, ONES, 32'h0001_0000},         // R8
    {8'd8, ity(7'b0100100,5'd9,3'b101), 32'h0000_0100, ONES, 32'h0},          // R8
    {8'd8, ity(7'b0100100,5'd8,3'b101), 32'h0000_0100, ONES, 32'h1},          // R8
    {8'd3, rty(7'b0000101,3'b110), 32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF} // R3
  };

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Drive one request at a falling edge; returns wait seen and the next-edge response.
  task automatic issue(logic [31:0] insn, logic [31:0] s1, logic [31:0] s2,
                       output logic w, output logic rdy, output logic wr, output logic [31:0] res);
    @(negedge clk);
    req_valid = 1'b1; req_insn = insn; req_src1 = s1; req_src2 = s2;
    #1 w = rsp_wait;
    @(negedge clk);
    rdy = rsp_ready; wr = rsp_wr; res = rsp_result;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic w, rdy, wr;
    logic [31:0] res;
    // R11: outputs zero under reset, with a claimable request pending
    req_valid = 1'b1; req_insn = rty(7'b0010000, 3'b010); req_src1 = 32'h10; req_src2 = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 ready in reset", {31'b0, rsp_ready}, 32'h0);
    chk("R11 wr in reset", {31'b0, rsp_wr}, 32'h0);
    chk("R11 result in reset", rsp_result, 32'h0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready after reset", {31'b0, rsp_ready}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      v = VEC[i];
      issue(v[127:96], v[95:64], v[63:32], w, rdy, wr, res);
      chk($sformatf("R%0d vector %0d result", v[135:128], i), res, v[31:0]);
      if (!(w && rdy && wr)) begin
        chk($sformatf("R9 handshake vector %0d", i), {29'b0, w, rdy, wr}, 32'h7);
      end else checks++;
    end

    // R10: unknown encodings
    issue(rty(7'b0000001, 3'b000), 32'h3, 32'h4, w, rdy, wr, res);
    chk("R10 mul-like wait/ready/wr", {29'b0, w, rdy, wr}, 32'h0);
    issue(rty(7'b0000101, 3'b001), 32'h3, 32'h4, w, rdy, wr, res);
    chk("R10 carry-less slot wait/ready/wr", {29'b0, w, rdy, wr}, 32'h0);
    issue(ity(7'b0110000, 5'd3, 3'b001), 32'h3, 32'h4, w, rdy, wr, res);
    chk("R10 count selector 3 wait/ready/wr", {29'b0, w, rdy, wr}, 32'h0);
    issue({7'b0000100, 5'd1, 5'd1, 3'b100, 5'd3, 7'b0110011}, 32'h3, 32'h4, w, rdy, wr, res);
    chk("R10 zext with rs2 field 1", {29'b0, w, rdy, wr}, 32'h0);

    // R9 and R12: valid held high across several cycles
    @(negedge clk);
    req_valid = 1'b1; req_insn = rty(7'b0010000, 3'b100); req_src1 = 32'h1; req_src2 = 32'h2;
    #1 chk("R9 wait in request cycle", {31'b0, rsp_wait}, 32'h1);
    chk("R9 ready not yet", {31'b0, rsp_ready}, 32'h0);
    @(negedge clk);
    chk("R9 ready next cycle", {30'b0, rsp_ready, rsp_wr}, 32'h3);
    chk("R9 result", rsp_result, 32'h6);
    @(negedge clk);
    chk("R12 no back-to-back ready", {30'b0, rsp_ready, rsp_wr}, 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 idle after drop", {31'b0, rsp_ready}, 32'h0);

    finish_run();
  end
endmodule